// File: doc/BRIEF.md
# Bit-Serial CRC-8 Generator and Identity Checker

This block computes an 8-bit cyclic redundancy code one bit at a time over the identity code and data streams of a single-wire bus. Neighbouring logic delivers each bit with a one-cycle enable, least significant bit first. The block keeps the running remainder in an 8-bit shift register and always presents its value at the outputs.

There are two ways to use it. To generate a code, clear the register and shift in the 56 identity bits: the family byte first, then the 48-bit serial number. The register then holds the check byte that completes the identity. To validate a received 64-bit identity, clear the register and shift in all 64 bits, including the received check byte. A correct code leaves a zero remainder. The block then raises a frame-valid flag, but only if exactly 64 bits have arrived since the last clear.

The generator polynomial is x^8 + x^5 + x^4 + 1. It is used in reflected form, shifting right, and the register starts at zero.

Top module: `crc8_serial`

## Requirements
- R1: While rst_n is low, and after it is released, crc_out is 8'h00, residue_zero is 1 and frame_ok is 0.
- R2: A cycle with clr high sets crc_out to 8'h00 and frame_ok to 0 from the next clock edge, and restarts the bit count.
- R3: When clr and bit_en are both high in one cycle, the clear wins and the presented bit is discarded.
- R4: On each bit step, feedback = bit_in XOR crc_out[0]. The register shifts right by one (bit 7 takes 0). When feedback is 1, the result is XORed with 8'h8C, which sets bit 7 and toggles bits 3 and 2.
- R5: crc_out changes only at a clock edge where bit_en or clr was high. The new value is visible right after that edge. With both low, crc_out holds.
- R6: After a clear and 56 bits fed LSB first, crc_out equals the CRC-8 (x^8+x^5+x^4+1, reflected, zero start) of those bits.
- R7: Shifting those 8 CRC bits in after the 56 data bits, LSB first, returns crc_out to 8'h00.
- R8: residue_zero is 1 exactly when crc_out is 8'h00.
- R9: frame_ok is 1 exactly when 64 bits have been shifted since the last clear or reset and crc_out is 8'h00. A wrong bit anywhere in the 64 keeps it low.
- R10: Once more than 64 bits have been shifted since the last clear, frame_ok stays 0 until the next clear, even when the remainder is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of remainder and bit count |
| bit_en | input | 1 | Accept bit_in this cycle |
| bit_in | input | 1 | Serial data bit |
| crc_out | output | 8 | Current remainder |
| residue_zero | output | 1 | Remainder is zero |
| frame_ok | output | 1 | Exactly 64 bits seen and remainder zero |

## Verification
Every result is registered once. A bit or clear given in one cycle therefore shows on crc_out, residue_zero and frame_ok directly after the next rising edge, with no further delay. The bench drives inputs on the falling edge and drops the enable after one edge. It samples on the following falling edge, half a period after the edge that updated the register. Hold behaviour is checked by sampling again after idle cycles without an enable.

// File: rtl/crc8_serial.sv
module crc8_serial #(
  parameter int          CRC_W      = 8,
  parameter logic [7:0]  POLY_REFL  = 8'h8C,
  parameter int          FRAME_BITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_out,
  output logic             residue_zero,
  output logic             frame_ok
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(FRAME_BITS + 1);

  logic [CRC_W-1:0] rem_q, rem_d;
  logic [CW-1:0]    cnt_q;
  logic             fb;

  assign fb    = bit_in ^ rem_q[0];
  assign rem_d = (rem_q >> 1) ^ (fb ? POLY_REFL[CRC_W-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else if (bit_en) begin
      rem_q <= rem_d;
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign crc_out      = rem_q;
  assign residue_zero = (rem_q == '0);
  assign frame_ok     = residue_zero && (cnt_q == CNT_FULL);
endmodule

module crc8_serial_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       bit_en,
  input logic       bit_in,
  input logic [7:0] crc_out,
  input logic       residue_zero,
  input logic       frame_ok
);
  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == 8'h00) && !frame_ok);
  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_en) |=> $stable(crc_out));
  // R9
  ok_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> residue_zero);
  // R4
  plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_en && !bit_in && !crc_out[0]) |=> crc_out == ($past(crc_out) >> 1));
  // R4
  fold_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_en && (bit_in != crc_out[0])) |=> crc_out[7]);
  // R10
  no_ok_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && bit_en && !clr) |=> !frame_ok);
endmodule

bind crc8_serial crc8_serial_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
  .crc_out(crc_out), .residue_zero(residue_zero), .frame_ok(frame_ok)
);

// File: tb/crc8_serial_tb.sv
module crc8_serial_tb;
  logic clk = 0, rst_n = 0, clr = 0, bit_en = 0, bit_in = 0;
  logic [7:0] crc_out;
  logic residue_zero, frame_ok;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  crc8_serial u_dut (.clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en),
    .bit_in(bit_in), .crc_out(crc_out), .residue_zero(residue_zero), .frame_ok(frame_ok));

  localparam int NV = 6;
  localparam logic [55:0] VEC [NV] = '{
    56'h00000000000000, 56'h000000000000_01, 56'hA1B2C3D4E5F6_28,
    56'hFFFFFFFFFFFF_FF, 56'h123456789ABC_0C, 56'h800000000000_00 };

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    logic [7:0] o;
    for (int i = 0; i < 56; i++) begin
      logic f = d[i] ^ r[7];
      r = {r[6:0], 1'b0} ^ (f ? 8'h31 : 8'h00);
    end
    for (int i = 0; i < 8; i++) o[i] = r[7-i];
    return o;
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift(input logic b);
    bit_en = 1; bit_in = b;
    @(negedge clk);
    bit_en = 0; bit_in = 0;
  endtask

  task automatic do_clear();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] e;
    @(negedge clk);
    chk("R1 in reset", {crc_out, residue_zero, frame_ok}, {8'h00, 1'b1, 1'b0});
    rst_n = 1; @(negedge clk);
    chk("R1 after reset", {crc_out, residue_zero, frame_ok}, {8'h00, 1'b1, 1'b0});

    for (int v = 0; v < NV; v++) begin
      do_clear();
      for (int i = 0; i < 56; i++) shift(VEC[v][i]);
      e = ref_crc(VEC[v]);
      chk("R6 crc after 56", {2'b00, crc_out}, {2'b00, e});
      chk("R8 residue flag", {9'd0, residue_zero}, {9'd0, e == 8'h00});
      chk("R9 not yet 64", {9'd0, frame_ok}, 10'd0);
      for (int i = 0; i < 8; i++) shift(e[i]);
      chk("R7 zero residue", {2'b00, crc_out}, 10'd0);
      chk("R9 frame ok", {9'd0, frame_ok}, 10'd1);
    end

    shift(1'b0);
    chk("R10 residue still zero", {2'b00, crc_out}, 10'd0);
    chk("R10 ok dropped", {9'd0, frame_ok}, 10'd0);

    do_clear();
    chk("R2 clear", {crc_out, residue_zero, frame_ok}, {8'h00, 1'b1, 1'b0});
    shift(1'b1);
    chk("R4 first one bit", {2'b00, crc_out}, {2'b00, 8'h8C});
    shift(1'b0);
    chk("R4 feedback from bit0=0", {2'b00, crc_out}, {2'b00, 8'h46});
    shift(1'b0);
    chk("R4 plain shift", {2'b00, crc_out}, {2'b00, 8'h23});
    shift(1'b0);
    chk("R4 feedback from bit0=1", {2'b00, crc_out}, {2'b00, 8'h9D});
    repeat (3) @(negedge clk);
    chk("R5 hold without enable", {2'b00, crc_out}, {2'b00, 8'h9D});
    chk("R8 nonzero flag", {9'd0, residue_zero}, 10'd0);

    clr = 1; bit_en = 1; bit_in = 1;
    @(negedge clk);
    clr = 0; bit_en = 0; bit_in = 0;
    chk("R3 clear wins", {2'b00, crc_out}, 10'd0);

    e = ref_crc(VEC[2]);
    for (int i = 0; i < 56; i++) shift(VEC[2][i]);
    for (int i = 0; i < 8; i++) shift(e[i]);
    chk("R3 count restarted by clear", {9'd0, frame_ok}, 10'd1);

    do_clear();
    for (int i = 0; i < 56; i++) shift(VEC[4][i] ^ (i == 17));
    e = ref_crc(VEC[4]);
    for (int i = 0; i < 8; i++) shift(e[i]);
    chk("R9 corrupted bit rejected", {9'd0, frame_ok}, 10'd0);

    do_clear();
    for (int i = 0; i < 70; i++) shift(1'b0);
    chk("R10 long zero run", {crc_out, residue_zero, frame_ok}, {8'h00, 1'b1, 1'b0});

    rst_n = 0; @(negedge clk);
    chk("R1 reset mid-use", {crc_out, residue_zero, frame_ok}, {8'h00, 1'b1, 1'b0});
    finish_run();
  end
endmodule